// File: doc/BRIEF.md
# Slice Register File, Q Register and Destination Router

This block is the storage and routing half of a 4-bit cascadable datapath slice. It holds a 16-word two-port register file and a separate Q working register. It presents the A-port, B-port and Q contents to an external arithmetic unit. That unit returns a result F, and a 3-bit destination code then decides what happens to it. The result can be written into the register file, with or without a one-bit shift. The Q register can be loaded or shifted. The slice output Y shows either F or the A-port word.

Shifts are arranged so that several slices can be chained into a wider word. Each shifter has an LSB end pin and an MSB end pin. In each end pin, one side carries the bit that leaves the slice and the other side carries the bit that enters it from a neighbour. The neighbour pins are modelled as separate data-in, data-out and drive-enable signals. Y is modelled the same way, with a drive enable controlled by an active-low output enable.

Reads are combinational from the stored state. The register-file write and the Q update both happen at the rising clock edge. During the whole cycle in which a word is being written, the A and B ports therefore show the word's old contents. This plays the role of holding latches in front of the read ports.

Top module: `slice_store_route`

## Requirements
- R1: Destination code 0 loads F into Q at the clock edge, writes no register-file word, and selects F onto Y.
- R2: Destination code 1 leaves Q and every register-file word unchanged and selects F onto Y.
- R3: Codes 2 and 3 write F unshifted into the word at the B address when write enable is high, and leave Q unchanged. Code 2 selects the A-port word onto Y, and code 3 selects F.
- R4: Codes 4 and 5 write {ramMsbIn, F[3:1]} to the B-address word and select F onto Y. Code 4 also loads {qMsbIn, Q[3:1]} into Q, and code 5 leaves Q unchanged.
- R5: Codes 6 and 7 write {F[2:0], ramLsbIn} to the B-address word and select F onto Y. Code 6 also loads {Q[2:0], qLsbIn} into Q, and code 7 leaves Q unchanged.
- R6: On a down shift (codes 4 and 5), ramLsbOut=F[0] and qLsbOut=Q[0] are driven with their enables high, and both MSB enables are low. On an up shift (codes 6 and 7), ramMsbOut=F[3] and qMsbOut=Q[3] are driven with their enables high, and both LSB enables are low.
- R7: For codes 0 to 3, all four end-pin enables are low.
- R8: aData and bData show the words at aAddr and bAddr, and they are equal when the two addresses match. In a cycle that writes a word, both ports still show that word's old contents, and the new contents appear after the edge.
- R9: With write enable low, no register-file word changes, while Q still follows the destination code.
- R10: yOe is the inverse of outEnN. When outEnN is high, Y is not driven.
- R11: An active-low asynchronous reset clears Q and every register-file word to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and Q updates on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| aAddr | input | 4 | A read address |
| bAddr | input | 4 | B read and write address |
| dest | input | 3 | Destination code |
| writeEn | input | 1 | Register-file write enable |
| outEnN | input | 1 | Active-low Y output enable |
| fIn | input | 4 | Result from the arithmetic unit |
| ramLsbIn | input | 1 | Bit entering the register-file shifter at the LSB (up shift) |
| ramMsbIn | input | 1 | Bit entering the register-file shifter at the MSB (down shift) |
| qLsbIn | input | 1 | Bit entering Q at the LSB (up shift) |
| qMsbIn | input | 1 | Bit entering Q at the MSB (down shift) |
| aData | output | 4 | A-port word |
| bData | output | 4 | B-port word |
| qData | output | 4 | Q register contents |
| yOut | output | 4 | Y data |
| yOe | output | 1 | Y drive enable |
| ramLsbOut | output | 1 | Register-file LSB leaving on a down shift |
| ramLsbOe | output | 1 | Drive enable for ramLsbOut |
| ramMsbOut | output | 1 | Register-file MSB leaving on an up shift |
| ramMsbOe | output | 1 | Drive enable for ramMsbOut |
| qLsbOut | output | 1 | Q LSB leaving on a down shift |
| qLsbOe | output | 1 | Drive enable for qLsbOut |
| qMsbOut | output | 1 | Q MSB leaving on an up shift |
| qMsbOe | output | 1 | Drive enable for qMsbOut |

## Verification
The hardest case to reach from the ports is a read of a word in the same cycle that it is being overwritten, with A and B pointing at the same address. The stimulus sets this up on purpose: it first seeds a known word, then issues a write to it with both addresses aimed at it. It checks the old value during that cycle and the new value after the edge. Random cycles then mix all eight codes, all addresses, both enable levels and random end-pin inputs. A reference model held in the bench tracks every word and Q.

// File: rtl/slice_route_pkg.sv
package slice_route_pkg;

  localparam int DATA_W = 4;
  localparam int WORDS  = 16;

  typedef enum logic [2:0] {
    DST_QLOAD  = 3'd0,
    DST_NONE   = 3'd1,
    DST_WRA    = 3'd2,
    DST_WRF    = 3'd3,
    DST_DNBOTH = 3'd4,
    DST_DNRAM  = 3'd5,
    DST_UPBOTH = 3'd6,
    DST_UPRAM  = 3'd7
  } destT;

  typedef struct packed {
    logic ramWrite;
    logic qLoad;
    logic shiftDown;
    logic shiftUp;
    logic ySelA;
  } strobeT;

endpackage

// File: rtl/slice_dest_decode.sv
module slice_dest_decode
  import slice_route_pkg::*;
(
  input  logic [2:0] dest,
  input  logic       writeEn,
  output strobeT     strb
);

  destT code;

  always_comb begin
    code           = destT'(dest);
    strb           = '0;
    unique case (code)
      DST_QLOAD:  strb.qLoad = 1'b1;
      DST_NONE:   ;
      DST_WRA:    begin strb.ramWrite = writeEn; strb.ySelA = 1'b1; end
      DST_WRF:    strb.ramWrite = writeEn;
      DST_DNBOTH: begin strb.ramWrite = writeEn; strb.qLoad = 1'b1; strb.shiftDown = 1'b1; end
      DST_DNRAM:  begin strb.ramWrite = writeEn; strb.shiftDown = 1'b1; end
      DST_UPBOTH: begin strb.ramWrite = writeEn; strb.qLoad = 1'b1; strb.shiftUp = 1'b1; end
      DST_UPRAM:  begin strb.ramWrite = writeEn; strb.shiftUp = 1'b1; end
      default:    ;
    endcase
  end

  // R6: a shift has exactly one direction
  always_comb begin
    a_r6_one_direction: assert (!(strb.shiftDown && strb.shiftUp));
  end

endmodule

// File: rtl/slice_datapath.sv
module slice_datapath
  import slice_route_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int DEPTH = WORDS,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobeT        strb,
  input  logic [AW-1:0] aAddr,
  input  logic [AW-1:0] bAddr,
  input  logic          outEnN,
  input  logic [W-1:0]  fIn,
  input  logic          ramLsbIn,
  input  logic          ramMsbIn,
  input  logic          qLsbIn,
  input  logic          qMsbIn,
  output logic [W-1:0]  aData,
  output logic [W-1:0]  bData,
  output logic [W-1:0]  qData,
  output logic [W-1:0]  yOut,
  output logic          yOe,
  output logic          ramLsbOut,
  output logic          ramLsbOe,
  output logic          ramMsbOut,
  output logic          ramMsbOe,
  output logic          qLsbOut,
  output logic          qLsbOe,
  output logic          qMsbOut,
  output logic          qMsbOe
);

  logic [DEPTH-1:0][W-1:0] mem;
  logic [W-1:0]            qReg;
  logic [W-1:0]            ramNext;
  logic [W-1:0]            qNext;

  // Shifter in front of the register file
  always_comb begin
    if (strb.shiftDown)      ramNext = {ramMsbIn, fIn[W-1:1]};
    else if (strb.shiftUp)   ramNext = {fIn[W-2:0], ramLsbIn};
    else                     ramNext = fIn;
  end

  // Shifter in front of Q
  always_comb begin
    if (strb.shiftDown)      qNext = {qMsbIn, qReg[W-1:1]};
    else if (strb.shiftUp)   qNext = {qReg[W-2:0], qLsbIn};
    else                     qNext = fIn;
  end

  // One write port per word, selected by the B address
  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_word
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                    mem[gi] <= '0;
      else if (strb.ramWrite && bAddr == AW'(gi))   mem[gi] <= ramNext;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           qReg <= '0;
    else if (strb.qLoad) qReg <= qNext;
  end

  // Reads see stored state only, so a word being written shows its old value
  assign aData = mem[aAddr];
  assign bData = mem[bAddr];
  assign qData = qReg;

  assign yOut = strb.ySelA ? aData : fIn;
  assign yOe  = ~outEnN;

  assign ramLsbOut = fIn[0];
  assign ramMsbOut = fIn[W-1];
  assign qLsbOut   = qReg[0];
  assign qMsbOut   = qReg[W-1];
  assign ramLsbOe  = strb.shiftDown;
  assign qLsbOe    = strb.shiftDown;
  assign ramMsbOe  = strb.shiftUp;
  assign qMsbOe    = strb.shiftUp;

  // R1: an unshifted Q load takes F
  a_r1_q_takes_f: assert property (@(posedge clk) disable iff (!rstN)
    (strb.qLoad && !strb.shiftDown && !strb.shiftUp) |=> (qReg == $past(fIn)));

  // R2: Q holds when not loaded
  a_r2_q_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.qLoad |=> $stable(qReg));

  // R9: no write strobe, no change in the file
  a_r9_file_holds: assert property (@(posedge clk) disable iff (!rstN)
    !strb.ramWrite |=> $stable(mem));

  // R4: down shift brings the MSB fill into the written word
  a_r4_down_fill: assert property (@(posedge clk) disable iff (!rstN)
    (strb.ramWrite && strb.shiftDown) |=> (mem[$past(bAddr)][W-1] == $past(ramMsbIn)));

  // R10: Y is released when the output enable is high
  a_r10_y_released: assert property (@(posedge clk) disable iff (!rstN)
    outEnN |-> !yOe);

  // R6: LSB and MSB drivers of one shifter are never on together
  a_r6_ends_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(ramLsbOe && ramMsbOe) && !(qLsbOe && qMsbOe));

endmodule

// File: rtl/slice_store_route.sv
module slice_store_route
  import slice_route_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [3:0] aAddr,
  input  logic [3:0] bAddr,
  input  logic [2:0] dest,
  input  logic       writeEn,
  input  logic       outEnN,
  input  logic [3:0] fIn,
  input  logic       ramLsbIn,
  input  logic       ramMsbIn,
  input  logic       qLsbIn,
  input  logic       qMsbIn,
  output logic [3:0] aData,
  output logic [3:0] bData,
  output logic [3:0] qData,
  output logic [3:0] yOut,
  output logic       yOe,
  output logic       ramLsbOut,
  output logic       ramLsbOe,
  output logic       ramMsbOut,
  output logic       ramMsbOe,
  output logic       qLsbOut,
  output logic       qLsbOe,
  output logic       qMsbOut,
  output logic       qMsbOe
);

  strobeT strb;

  slice_dest_decode u_decode (
    .dest    (dest),
    .writeEn (writeEn),
    .strb    (strb)
  );

  slice_datapath #(.W(DATA_W), .DEPTH(WORDS)) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .aAddr     (aAddr),
    .bAddr     (bAddr),
    .outEnN    (outEnN),
    .fIn       (fIn),
    .ramLsbIn  (ramLsbIn),
    .ramMsbIn  (ramMsbIn),
    .qLsbIn    (qLsbIn),
    .qMsbIn    (qMsbIn),
    .aData     (aData),
    .bData     (bData),
    .qData     (qData),
    .yOut      (yOut),
    .yOe       (yOe),
    .ramLsbOut (ramLsbOut),
    .ramLsbOe  (ramLsbOe),
    .ramMsbOut (ramMsbOut),
    .ramMsbOe  (ramMsbOe),
    .qLsbOut   (qLsbOut),
    .qLsbOe    (qLsbOe),
    .qMsbOut   (qMsbOut),
    .qMsbOe    (qMsbOe)
  );

  // R7: no end pin is driven for the unshifted codes
  a_r7_no_shift_quiet: assert property (@(posedge clk) disable iff (!rstN)
    (dest <= 3'd3) |-> !(ramLsbOe || ramMsbOe || qLsbOe || qMsbOe));

endmodule

// File: tb/sim_slice_store_route.sv
`timescale 1ns/1ps
module sim_slice_store_route;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] aAddr = '0, bAddr = '0, fIn = '0;
  logic [2:0] dest = 3'd1;
  logic       writeEn = 1'b0, outEnN = 1'b0;
  logic       ramLsbIn = 1'b0, ramMsbIn = 1'b0, qLsbIn = 1'b0, qMsbIn = 1'b0;
  logic [3:0] aData, bData, qData, yOut;
  logic       yOe, ramLsbOut, ramLsbOe, ramMsbOut, ramMsbOe;
  logic       qLsbOut, qLsbOe, qMsbOut, qMsbOe;

  int errors = 0;
  int checks = 0;
  logic [3:0] refMem [16];
  logic [3:0] refQ;

  always #2.5 clk = ~clk;

  slice_store_route u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] expWord(input logic [2:0] d, input logic [3:0] f,
                                         input logic lsbIn, input logic msbIn);
    if (d == 3'd4 || d == 3'd5) return {msbIn, f[3:1]};
    if (d == 3'd6 || d == 3'd7) return {f[2:0], lsbIn};
    return f;
  endfunction

  function automatic logic [3:0] expQ(input logic [2:0] d, input logic [3:0] q,
                                      input logic [3:0] f, input logic lsbIn, input logic msbIn);
    if (d == 3'd0) return f;
    if (d == 3'd4) return {msbIn, q[3:1]};
    if (d == 3'd6) return {q[2:0], lsbIn};
    return q;
  endfunction

  // Drive one cycle at the falling edge, check mid-cycle, update model at rising edge
  task automatic step(input logic [2:0] d, input logic [3:0] a, input logic [3:0] b,
                      input logic [3:0] f, input logic we, input logic oen,
                      input logic [3:0] pins);
    logic [3:0] y;
    bit down, up;
    @(negedge clk);
    dest = d; aAddr = a; bAddr = b; fIn = f; writeEn = we; outEnN = oen;
    {ramLsbIn, ramMsbIn, qLsbIn, qMsbIn} = pins;
    #1;
    down = (d == 3'd4 || d == 3'd5);
    up   = (d == 3'd6 || d == 3'd7);
    y = (d == 3'd2) ? refMem[a] : f;
    chk(aData == refMem[a], "R8 aData", aData, refMem[a]);
    chk(bData == refMem[b], "R8 bData", bData, refMem[b]);
    chk(qData == refQ, "R1 qData", qData, refQ);
    chk(yOut == y, (d == 3'd2) ? "R3 yOut A-port" : "R2 yOut F", yOut, y);
    chk(yOe == !oen, "R10 yOe", yOe, !oen);
    chk({ramLsbOe, qLsbOe, ramMsbOe, qMsbOe} == {down, down, up, up},
        down ? "R6 down enables" : (up ? "R6 up enables" : "R7 enables off"),
        {ramLsbOe, qLsbOe, ramMsbOe, qMsbOe}, {down, down, up, up});
    if (down) chk({ramLsbOut, qLsbOut} == {f[0], refQ[0]}, "R6 lsb out",
                  {ramLsbOut, qLsbOut}, {f[0], refQ[0]});
    if (up)   chk({ramMsbOut, qMsbOut} == {f[3], refQ[3]}, "R6 msb out",
                  {ramMsbOut, qMsbOut}, {f[3], refQ[3]});
    @(posedge clk);
    if (we && d >= 3'd2) refMem[b] = expWord(d, f, pins[3], pins[2]);
    refQ = expQ(d, refQ, f, pins[1], pins[0]);
  endtask

  initial begin : watchdog
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1));
    for (int i = 0; i < 16; i++) refMem[i] = '0;
    refQ = '0;
    repeat (3) @(posedge clk);
    // R11: reset clears storage
    #1;
    chk(qData == 4'h0, "R11 Q reset", qData, 0);
    for (int i = 0; i < 16; i++) begin
      aAddr = 4'(i); #1;
      chk(aData == 4'h0, "R11 word reset", aData, 0);
    end
    @(negedge clk); rstN = 1'b1;

    // R1: load Q
    step(3'd0, 4'h3, 4'h3, 4'hA, 1'b1, 1'b0, 4'h0);
    step(3'd1, 4'h3, 4'h3, 4'h0, 1'b1, 1'b0, 4'h0);
    chk(qData == 4'hA && bData == 4'h0, "R1 Q loaded no file write", qData, 4'hA);
    // R8: seed word 5, then overwrite with A=B=5
    step(3'd3, 4'h0, 4'h5, 4'h6, 1'b1, 1'b0, 4'h0);
    step(3'd3, 4'h5, 4'h5, 4'h9, 1'b1, 1'b0, 4'h0);
    step(3'd2, 4'h5, 4'h5, 4'h1, 1'b0, 1'b0, 4'h0);
    chk(aData == 4'h9 && bData == 4'h9, "R8 new value after edge", aData, 4'h9);
    // R9: writeEn low holds the word
    step(3'd5, 4'h5, 4'h5, 4'hF, 1'b0, 1'b0, 4'hF);
    step(3'd1, 4'h5, 4'h5, 4'h0, 1'b0, 1'b0, 4'h0);
    chk(aData == 4'h9, "R9 word unchanged", aData, 4'h9);
    // R4/R5: directed shifts with end fills
    step(3'd4, 4'h0, 4'h7, 4'hC, 1'b1, 1'b0, 4'b0101);
    step(3'd6, 4'h7, 4'h8, 4'h5, 1'b1, 1'b0, 4'b1010);
    step(3'd1, 4'h7, 4'h8, 4'h0, 1'b0, 1'b1, 4'h0);
    chk(aData == 4'hE && bData == 4'hB, "R4 R5 shifted words", {aData, bData}, 8'hEB);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      step(3'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
           1'($urandom), 1'($urandom), 4'($urandom));
    end
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule